// File: doc/BRIEF.md
# Configurable GPIO Interrupt Detector

This block turns the eight synchronized input pins of a GPIO port into interrupt requests. Software picks a detection mode for each pin: level-sensitive (active high or active low), a single edge (rising or falling), or both edges. Each pin keeps a raw interrupt status bit. A per-pin enable mask turns the raw status into a masked status, and a single interrupt output is the OR of all masked bits.

Edge events are latched until software writes ones to a clear register. A level-sensitive pin's status follows the pin directly and cannot be cleared while the pin stays at its active level. An interrupt handler reads the masked status and writes that same value back to the clear register to acknowledge every pending edge.

Registers sit on a simple register bus with a write strobe and a combinational read path. The data and direction parts of the port are handled elsewhere.

Top module: `pin_event_unit`

## Requirements
- R1: Bit n of the sense register (offset 0x404) selects level detection for pin n when 1 and edge detection when 0.
- R2: For a level-sensitive pin, raw status bit n equals 1 in the same cycle in which the pin equals the polarity bit (1 = high active, 0 = low active). It drops as soon as the pin leaves that level, and a clear write has no effect on it.
- R3: For an edge-sensitive pin with the dual-edge bit at 0, polarity bit 1 latches a rising edge and polarity bit 0 latches a falling edge. An edge is found by comparing the pin with its sample from the previous cycle. The latched bit is visible in raw status right after the clock edge at which the edge is sampled.
- R4: Bit n of the dual-edge register (offset 0x408) set to 1 makes an edge-sensitive pin latch both rising and falling edges, whatever its polarity bit (offset 0x40C).
- R5: Writing to the clear register (offset 0x41C) clears every latched edge bit written as 1 and leaves every bit written as 0 unchanged. The clear register reads as 0.
- R6: If an edge is detected in the same cycle as a clear of that pin, the raw status bit stays set.
- R7: Masked status (offset 0x418) equals raw status (offset 0x414) AND the enable register (offset 0x410). The interrupt output is 1 exactly when any masked bit is 1.
- R8: After reset, the sense, dual-edge, polarity and enable registers read 0, no edge is latched, masked status reads 0 and the interrupt output is 0.
- R9: Writing the sense, dual-edge or polarity registers never latches an edge by itself. The previous-sample register is updated every cycle, whatever the configuration.
- R10: The raw and masked status registers are read-only: writes to 0x414 and 0x418 are ignored. Reads from unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pins_in | input | 8 | Synchronized pin levels |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench sets all eight pins to different modes at the same time and walks a sequence of pin patterns. This shows whether the wrong polarity or the wrong edge latches, and whether a dual-edge pin still obeys its polarity bit. A clear written in the same cycle as a new edge catches a design that lets the clear win and drops an event. Rewriting the mode registers while the pins are steady catches a design that makes an edge out of a configuration change. A clear aimed at a level-sensitive pin, writes to the read-only offsets and the read-back-then-clear acknowledge flow expose designs that let software erase a live level, corrupt status, or leave the interrupt output high after the acknowledge.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_SENSE  = 12'h404;
    localparam logic [ADDR_W-1:0] OFS_DUAL   = 12'h408;
    localparam logic [ADDR_W-1:0] OFS_POL    = 12'h40C;
    localparam logic [ADDR_W-1:0] OFS_EN     = 12'h410;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 12'h414;
    localparam logic [ADDR_W-1:0] OFS_MASKED = 12'h418;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 12'h41C;

    typedef enum logic [2:0] {
        SEL_SENSE,
        SEL_DUAL,
        SEL_POL,
        SEL_EN,
        SEL_RAW,
        SEL_MASKED,
        SEL_CLEAR,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        unique case (a)
            OFS_SENSE:  s = SEL_SENSE;
            OFS_DUAL:   s = SEL_DUAL;
            OFS_POL:    s = SEL_POL;
            OFS_EN:     s = SEL_EN;
            OFS_RAW:    s = SEL_RAW;
            OFS_MASKED: s = SEL_MASKED;
            OFS_CLEAR:  s = SEL_CLEAR;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pin_event_regs.sv
module pin_event_regs
    import pin_event_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [W-1:0]      bus_wdata,
    input  logic [W-1:0]      raw_stat,
    output logic [W-1:0]      sense_q,
    output logic [W-1:0]      dual_q,
    output logic [W-1:0]      pol_q,
    output logic [W-1:0]      en_q,
    output logic [W-1:0]      clr_pulse,
    output logic [W-1:0]      bus_rdata
);

    reg_sel_e sel;

    assign sel = decode_offset(bus_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            sense_q <= '0;
            dual_q  <= '0;
            pol_q   <= '0;
            en_q    <= '0;
        end else if (bus_we) begin
            unique case (sel)
                SEL_SENSE: sense_q <= bus_wdata;
                SEL_DUAL:  dual_q  <= bus_wdata;
                SEL_POL:   pol_q   <= bus_wdata;
                SEL_EN:    en_q    <= bus_wdata;
                default:   ;
            endcase
        end
    end

    assign clr_pulse = (bus_we && sel == SEL_CLEAR) ? bus_wdata : '0;

    always_comb begin
        unique case (sel)
            SEL_SENSE:  bus_rdata = sense_q;
            SEL_DUAL:   bus_rdata = dual_q;
            SEL_POL:    bus_rdata = pol_q;
            SEL_EN:     bus_rdata = en_q;
            SEL_RAW:    bus_rdata = raw_stat;
            SEL_MASKED: bus_rdata = raw_stat & en_q;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pin_event_lane.sv
module pin_event_lane (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic level_mode,
    input  logic both_edges,
    input  logic polarity,
    input  logic clr,
    output logic prev_q,
    output logic raw
);

    logic edge_q;
    logic rise;
    logic fall;
    logic hit;

    assign rise = pin & ~prev_q;
    assign fall = ~pin & prev_q;
    assign hit  = both_edges ? (rise | fall) : (polarity ? rise : fall);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            edge_q <= 1'b0;
        end else begin
            prev_q <= pin;
            if (!level_mode && hit)
                edge_q <= 1'b1;
            else if (clr)
                edge_q <= 1'b0;
        end
    end

    assign raw = level_mode ? (pin == polarity) : edge_q;

endmodule

// File: rtl/pin_event_unit.sv
module pin_event_unit
    import pin_event_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pins_in,
    output logic              irq_out
);

    logic [W-1:0] sense_q;
    logic [W-1:0] dual_q;
    logic [W-1:0] pol_q;
    logic [W-1:0] en_q;
    logic [W-1:0] clr_pulse;
    logic [W-1:0] raw_stat;
    logic [W-1:0] pin_prev;

    pin_event_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .raw_stat  (raw_stat),
        .sense_q   (sense_q),
        .dual_q    (dual_q),
        .pol_q     (pol_q),
        .en_q      (en_q),
        .clr_pulse (clr_pulse),
        .bus_rdata (bus_rdata)
    );

    for (genvar i = 0; i < W; i++) begin : g_lane
        pin_event_lane u_lane (
            .clk        (clk),
            .rst        (rst),
            .pin        (pins_in[i]),
            .level_mode (sense_q[i]),
            .both_edges (dual_q[i]),
            .polarity   (pol_q[i]),
            .clr        (clr_pulse[i]),
            .prev_q     (pin_prev[i]),
            .raw        (raw_stat[i])
        );
    end

    assign irq_out = |(raw_stat & en_q);

endmodule

// File: rtl/pin_event_chk.sv
module pin_event_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] pins_in,
    input logic [W-1:0] pin_prev,
    input logic [W-1:0] sense_q,
    input logic [W-1:0] dual_q,
    input logic [W-1:0] pol_q,
    input logic [W-1:0] en_q,
    input logic [W-1:0] clr_pulse,
    input logic [W-1:0] raw_stat,
    input logic         irq_out
);

    // R8: enable register is zero in the cycle after reset
    a_r8_enable_reset: assert property (@(posedge clk) rst |=> (en_q == '0));

    // R7: nothing enabled means no interrupt
    a_r7_no_irq_when_off: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> !irq_out);

    for (genvar i = 0; i < W; i++) begin : g_pin
        // R4 and R6: any change on a dual-edge pin latches, even with a clear
        a_r4_dual_latch: assert property (@(posedge clk) disable iff (rst)
            (!sense_q[i] && dual_q[i] && (pins_in[i] != pin_prev[i]))
            |=> (raw_stat[i] || sense_q[i]));

        // R3 and R6: the selected single edge latches
        a_r3_single_latch: assert property (@(posedge clk) disable iff (rst)
            (!sense_q[i] && !dual_q[i] &&
             (pol_q[i] ? (pins_in[i] && !pin_prev[i]) : (!pins_in[i] && pin_prev[i])))
            |=> (raw_stat[i] || sense_q[i]));

        // R5: a clear with no new edge empties the latch
        a_r5_clear_drops: assert property (@(posedge clk) disable iff (rst)
            (!sense_q[i] && clr_pulse[i] && (pins_in[i] == pin_prev[i]))
            |=> (!raw_stat[i] || sense_q[i]));

        // R9: without a pin change an empty latch stays empty
        a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
            (!sense_q[i] && !raw_stat[i] && (pins_in[i] == pin_prev[i]))
            |=> (!raw_stat[i] || sense_q[i]));

        // R9: the previous sample tracks the pin every cycle
        a_r9_prev_tracks: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (pin_prev[i] == $past(pins_in[i])));
    end

endmodule

bind pin_event_unit pin_event_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pins_in   (pins_in),
    .pin_prev  (pin_prev),
    .sense_q   (sense_q),
    .dual_q    (dual_q),
    .pol_q     (pol_q),
    .en_q      (en_q),
    .clr_pulse (clr_pulse),
    .raw_stat  (raw_stat),
    .irq_out   (irq_out)
);

// File: tb/tb_pin_event_unit.sv
module tb_pin_event_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = 12'h000;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [7:0]  pins_in = 8'h00;
    logic        irq_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pin_event_unit dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pins_in   (pins_in),
        .irq_out   (irq_out)
    );

    // Entry: {pins, clear mask, expected raw after the clock edge}
    // Modes: p0 level high, p1 level low, p2 rise, p3 fall,
    //        p4 dual (pol 0), p5 dual (pol 1), p6 rise, p7 fall
    localparam int NSTEP = 10;
    localparam logic [23:0] STEPS [NSTEP] = '{
        {8'h00, 8'h00, 8'h02},
        {8'hFF, 8'h00, 8'h75},
        {8'hFF, 8'hFF, 8'h01},
        {8'h00, 8'h00, 8'hBA},
        {8'h00, 8'h0F, 8'hB2},
        {8'h00, 8'hF0, 8'h02},
        {8'h30, 8'h30, 8'h32},
        {8'h04, 8'h30, 8'h36},
        {8'h04, 8'hFF, 8'h02},
        {8'h05, 8'h00, 8'h03}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_check(input string req, input logic [11:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R8 reset state
        rd_check("R8 sense", 12'h404, 8'h00);
        rd_check("R8 dual", 12'h408, 8'h00);
        rd_check("R8 pol", 12'h40C, 8'h00);
        rd_check("R8 enable", 12'h410, 8'h00);
        rd_check("R8 masked", 12'h418, 8'h00);
        check("R8 irq", {7'd0, irq_out}, 8'h00);

        // Configure modes and read back (R10 offsets, R1 sense)
        wr(12'h404, 8'h03);
        wr(12'h408, 8'h30);
        wr(12'h40C, 8'h65);
        rd_check("R1 sense readback", 12'h404, 8'h03);
        rd_check("R10 dual readback", 12'h408, 8'h30);
        rd_check("R10 pol readback", 12'h40C, 8'h65);

        // Vector table: R2 R3 R4 R5 R6
        for (int k = 0; k < NSTEP; k++) begin
            @(negedge clk);
            pins_in   = STEPS[k][23:16];
            bus_addr  = 12'h41C;
            bus_wdata = STEPS[k][15:8];
            bus_we    = 1'b1;
            @(negedge clk);
            bus_we = 1'b0;
            rd_check($sformatf("R2/R3/R4/R5/R6 step %0d", k), 12'h414, STEPS[k][7:0]);
        end

        // R7 masking and combined output, raw is 0x03
        check("R7 irq off while disabled", {7'd0, irq_out}, 8'h00);
        rd_check("R7 masked disabled", 12'h418, 8'h00);
        wr(12'h410, 8'h02);
        rd_check("R7 masked one pin", 12'h418, 8'h02);
        check("R7 irq on", {7'd0, irq_out}, 8'h01);

        // R2 level pins ignore clear
        wr(12'h41C, 8'h03);
        rd_check("R2 level not cleared", 12'h414, 8'h03);

        // R9 and R1: mode rewrites with steady pins latch nothing
        wr(12'h404, 8'h00);
        rd_check("R1 edge mode steady pins", 12'h414, 8'h00);
        wr(12'h40C, 8'h00);
        wr(12'h408, 8'hFF);
        wr(12'h408, 8'h00);
        rd_check("R9 config no event", 12'h414, 8'h00);
        check("R9 irq quiet", {7'd0, irq_out}, 8'h00);

        // R5 and R7 acknowledge flow: all falling edges now
        wr(12'h410, 8'hFF);
        @(negedge clk);
        pins_in = 8'h00;
        @(negedge clk);
        rd_check("R3 falling latched", 12'h414, 8'h05);
        check("R7 irq pending", {7'd0, irq_out}, 8'h01);
        rd(12'h418, v);
        check("R7 masked pending", v, 8'h05);
        wr(12'h41C, v);
        rd_check("R5 ack clears", 12'h414, 8'h00);
        check("R5 irq after ack", {7'd0, irq_out}, 8'h00);

        // R10 read-only and unmapped offsets, R5 clear reads zero
        @(negedge clk);
        pins_in = 8'h01;
        @(negedge clk);
        pins_in = 8'h00;
        @(negedge clk);
        rd_check("R10 raw before write", 12'h414, 8'h01);
        wr(12'h414, 8'hFF);
        wr(12'h418, 8'hFE);
        rd_check("R10 raw write ignored", 12'h414, 8'h01);
        rd_check("R10 enable unchanged", 12'h410, 8'hFF);
        rd_check("R10 sense unchanged", 12'h404, 8'h00);
        rd_check("R5 clear reads zero", 12'h41C, 8'h00);
        rd_check("R10 unmapped", 12'h400, 8'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule